// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a system bus. Software writes a small set of registers, and a down-counter then guards the running code. The counter does not move after reset until software writes a two-step refresh key, 00h followed by FFh. Each later key reloads the counter, but only when the remaining count lies inside a window. The window is framed by a start position and an end position, each given as a quarter of the period.

A missed refresh lets the counter run out. A refresh that arrives too early or too late is refused. Either event latches a flag in the status register and sends a one-cycle pulse. The pulse goes out on the interrupt line or on the reset-request line, whichever a routing bit selects. Timeout length, divider and window are set once, between reset release and the first refresh. After that the configuration is fixed until the next reset.

Top module: `win_watchdog`

## Requirements
- R1: Reading byte address 2 returns the control register, 4 returns the status register (bit 0 underflow, bit 1 refresh error) and 6 returns the routing register in bits 7:0. All three read zero after reset.
- R2: After reset the counter stays idle and no pulse is produced until a write of 00h to address 0 is followed by a write of FFh to address 0.
- R3: A write of FFh to address 0 that does not directly follow a 00h write to address 0 neither starts nor reloads the counter. The same holds for any other value written there.
- R4: Control bits 1:0 select a period of 1024, 4096, 8192 or 16384 count ticks (codes 00, 01, 10, 11). With divide-by-1, the first underflow pulse appears exactly one period of clock cycles after the clock edge that accepted the key.
- R5: Control bits 7:4 equal to 0101 make one count tick every 256 clocks. Any other code gives one tick per clock.
- R6: The control and routing registers each accept only their first write, and only while the counter has not yet been started. Later writes leave them unchanged.
- R7: The refresh window is open when the remaining count c satisfies E <= c < S. S is 25, 50, 75 or 100 % of the period for control bits 13:12 = 00, 01, 10, 11. E is 75, 50, 25 or 0 % for control bits 9:8 = 00, 01, 10, 11.
- R8: A key completed while the counter runs and the window is closed sets status bit 1 and sends a pulse. The counter is not reloaded.
- R9: When the counter expires, status bit 0 is set and a pulse is sent. The counter then reloads and keeps counting.
- R10: Routing bit 7 = 0 sends the pulses to irq_o. Routing bit 7 = 1 sends them to rst_req_o.
- R11: Writing a 0 into a status bit clears it and writing a 1 leaves it. A new event in the same cycle wins over the clear.
- R12: Each pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_o | output | 1 | Interrupt pulse |
| rst_req_o | output | 1 | Reset-request pulse |

## Verification
The hardest case to reach is a refresh that lands just inside or just outside the window. It depends on the counter's remaining value at the exact clock edge where the FFh write lands. The bench keeps a free-running cycle count and places each key at a chosen number of cycles after the previous accepted one, well clear of the window edges. From that count it predicts both the immediate error pulse and the later underflow time, which would move if the refused key had reloaded the counter. The slow divider is proven through the same window: one timing that is refused with divide-by-1 is accepted with divide-by-256.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int BASE_LEN = 1024,
  parameter int SLOW_DIV = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int CW = $clog2(BASE_LEN) + 4;
  localparam int PW = $clog2(SLOW_DIV);
  localparam logic [CW:0] P0 = (CW+1)'(BASE_LEN);
  localparam logic [PW-1:0] PRE_LAST = PW'(SLOW_DIV - 1);

  logic [15:0]   ctrl_q;
  logic [7:0]    route_q;
  logic          ctrl_set, route_set, running, key_armed;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pre;
  logic          uf_flag, re_flag, irq_q, rr_q;

  wire wr_key   = bus_we && bus_addr == 3'd0;
  wire wr_ctrl  = bus_we && bus_addr == 3'd2;
  wire wr_stat  = bus_we && bus_addr == 3'd4;
  wire wr_route = bus_we && bus_addr == 3'd6;
  wire key_done = wr_key && key_armed && bus_wdata[7:0] == 8'hFF;

  logic [CW:0] period, quarter, start_lim, end_lim, reload_val;
  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   period = P0;
      2'b01:   period = P0 << 2;
      2'b10:   period = P0 << 3;
      default: period = P0 << 4;
    endcase
    quarter = period >> 2;
    case (ctrl_q[13:12])
      2'b00:   start_lim = quarter;
      2'b01:   start_lim = quarter << 1;
      2'b10:   start_lim = quarter + (quarter << 1);
      default: start_lim = period;
    endcase
    case (ctrl_q[9:8])
      2'b00:   end_lim = quarter + (quarter << 1);
      2'b01:   end_lim = quarter << 1;
      2'b10:   end_lim = quarter;
      default: end_lim = '0;
    endcase
    reload_val = period - 1'b1;
  end

  wire slow   = ctrl_q[7:4] == 4'b0101;
  wire tick   = running && (!slow || pre == PRE_LAST);
  wire in_win = ({1'b0, cnt} < start_lim) && ({1'b0, cnt} >= end_lim);
  wire uf_evt = tick && cnt == '0;
  wire re_evt = key_done && running && !in_win;
  wire reload = uf_evt || (key_done && (!running || in_win));
  wire evt    = uf_evt || re_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      route_q   <= '0;
      ctrl_set  <= 1'b0;
      route_set <= 1'b0;
      running   <= 1'b0;
      key_armed <= 1'b0;
      cnt       <= '0;
      pre       <= '0;
      uf_flag   <= 1'b0;
      re_flag   <= 1'b0;
      irq_q     <= 1'b0;
      rr_q      <= 1'b0;
    end else begin
      if (wr_ctrl && !ctrl_set && !running) begin
        ctrl_q   <= bus_wdata;
        ctrl_set <= 1'b1;
      end
      if (wr_route && !route_set && !running) begin
        route_q   <= bus_wdata[7:0];
        route_set <= 1'b1;
      end
      if (wr_key) key_armed <= bus_wdata[7:0] == 8'h00;
      if (key_done) running <= 1'b1;
      if (reload) begin
        cnt <= reload_val[CW-1:0];
        pre <= '0;
      end else if (running) begin
        if (tick) cnt <= cnt - 1'b1;
        pre <= (!slow || tick) ? '0 : pre + 1'b1;
      end
      uf_flag <= uf_evt || (uf_flag && !(wr_stat && !bus_wdata[0]));
      re_flag <= re_evt || (re_flag && !(wr_stat && !bus_wdata[1]));
      irq_q   <= evt && !route_q[7];
      rr_q    <= evt && route_q[7];
    end
  end

  always_comb begin
    case (bus_addr)
      3'd2:    bus_rdata = ctrl_q;
      3'd4:    bus_rdata = {14'b0, re_flag, uf_flag};
      3'd6:    bus_rdata = {8'b0, route_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rr_q;

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !running |=> !(irq_o || rst_req_o));
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    running && $past(running) |-> $stable(ctrl_q) && $stable(route_q));
  p_pulse_flagged_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_o || rst_req_o) |-> (uf_flag || re_flag));
  p_one_route_r10: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && rst_req_o));
  p_irq_single_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  p_rr_single_r12: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
endmodule

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;
  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o, rst_req_o;
  int checks = 0, errors = 0, cyc = 0, irq_cnt = 0, rr_cnt = 0;
  bit done = 0;

  win_watchdog u_win_watchdog (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (irq_o) irq_cnt++;
    if (rst_req_o) rr_cnt++;
  end
  always @(negedge clk) if (cyc > 150000 && !done) begin
    errors++;
    $display("FAIL watchdog expired at cycle %0d, expected end before 150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata); bus_addr = '0;
  endtask

  task automatic kick(output int t);
    wr(3'd0, 16'h0000); wr(3'd0, 16'h00FF); t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
  endtask

  task automatic wait_pulse(input bit on_rr, input int t0, input int lim, output int dt);
    dt = -1;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (on_rr ? rst_req_o : irq_o) begin dt = cyc - t0; break; end
    end
  endtask

  task automatic t_reset;
    int v, c0;
    do_reset;
    rd(3'd2, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 status reset", v, 0);
    rd(3'd6, v); chk(v == 0, "R1 route reset", v, 0);
    c0 = irq_cnt + rr_cnt; idle(1200);
    chk(irq_cnt + rr_cnt == c0, "R2 idle without key", irq_cnt + rr_cnt - c0, 0);
  endtask

  task automatic t_timeout;
    int t0, dt, v;
    do_reset;
    kick(t0);
    wait_pulse(0, t0, 2000, dt);
    chk(dt == 1024, "R4 period 1024", dt, 1024);
    @(negedge clk); chk(irq_o == 0, "R12 pulse width", int'(irq_o), 0);
    rd(3'd4, v); chk(v == 1, "R9 underflow flag", v, 1);
    wait_pulse(0, t0, 2200, dt);
    chk(dt == 2048, "R9 reload continues", dt, 2048);
    wr(3'd4, 16'h0002); rd(3'd4, v); chk(v == 0, "R11 clear underflow", v, 0);
  endtask

  task automatic t_long;
    int t0, dt;
    do_reset;
    wr(3'd2, 16'h0003); kick(t0);
    wait_pulse(0, t0, 17000, dt);
    chk(dt == 16384, "R4 period 16384", dt, 16384);
  endtask

  task automatic t_key;
    int t0, dt, c0;
    do_reset;
    c0 = irq_cnt;
    wr(3'd0, 16'h0000); wr(3'd0, 16'h0055); wr(3'd0, 16'h00FF);
    wr(3'd0, 16'h00FF);
    idle(1200);
    chk(irq_cnt == c0, "R3 broken key", irq_cnt - c0, 0);
    kick(t0);
    wait_pulse(0, t0, 2000, dt);
    chk(dt == 1024, "R2 key starts", dt, 1024);
  endtask

  task automatic t_lock_route;
    int t0, dt, v, c0;
    do_reset;
    wr(3'd2, 16'h0001); wr(3'd2, 16'h0002);
    rd(3'd2, v); chk(v == 1, "R6 second ctrl write", v, 1);
    wr(3'd6, 16'h0080); wr(3'd6, 16'h0000);
    rd(3'd6, v); chk(v == 'h80, "R6 second route write", v, 'h80);
    kick(t0);
    wr(3'd2, 16'h0003); rd(3'd2, v); chk(v == 1, "R6 write after start", v, 1);
    c0 = irq_cnt;
    wait_pulse(1, t0, 5000, dt);
    chk(dt == 4096, "R10 reset request at 4096", dt, 4096);
    chk(irq_cnt == c0, "R10 no irq", irq_cnt - c0, 0);
  endtask

  task automatic t_window;
    int t0, t1, t2, dt, v, c0;
    do_reset;
    wr(3'd2, 16'h1200);
    kick(t0);
    idle(600);
    c0 = irq_cnt;
    kick(t1);
    @(negedge clk);
    chk(irq_cnt == c0, "R7 in-window accepted", irq_cnt - c0, 0);
    rd(3'd4, v); chk(v == 0, "R7 no error flag", v, 0);
    idle(50);
    kick(t2);
    chk(irq_o == 1, "R8 early key pulse", int'(irq_o), 1);
    rd(3'd4, v); chk(v == 2, "R8 error flag", v, 2);
    wait_pulse(0, t1, 2000, dt);
    chk(dt == 1024, "R8 no reload", dt, 1024);
    rd(3'd4, v); chk(v == 3, "R9 both flags", v, 3);
    wr(3'd4, 16'h0002); rd(3'd4, v); chk(v == 2, "R11 write one keeps", v, 2);
    wr(3'd4, 16'h0000); rd(3'd4, v); chk(v == 0, "R11 write zero clears", v, 0);
  endtask

  task automatic t_div;
    int t0, t1, v, c0;
    do_reset;
    wr(3'd2, 16'h3050); kick(t0);
    idle(300); c0 = irq_cnt; kick(t1); @(negedge clk);
    rd(3'd4, v);
    chk(v == 0 && irq_cnt == c0, "R5 divide 256 keeps window", v, 0);
    do_reset;
    wr(3'd2, 16'h3000); kick(t0);
    idle(300); kick(t1);
    rd(3'd4, v); chk(v == 2, "R5 divide 1 leaves window", v, 2);
  endtask

  initial begin
    idle(1);
    t_reset;
    t_timeout;
    t_long;
    t_key;
    t_lock_route;
    t_window;
    t_div;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule